// File: doc/BRIEF.md
# Legacy System Port B Status and Control Register

This block holds the byte-wide system control register that legacy firmware reaches at I/O address 061h. Its low four bits are read/write controls: one drives the gate input of timer counter 2, one decides whether the counter 2 output reaches the speaker, and two mask the two error sources that can raise a non-maskable interrupt. Its high four bits are read-only and show the state of the system. They are two sticky error flags, the live counter 2 output, and a bit that flips on every falling edge of the counter 1 output.

A PCI parity/system error pulse is recorded in one sticky flag, and an I/O-check error level in the other. Each flag can be set only while its mask bit is 0. Each flag is cleared when software writes 1 to its mask bit. The NMI request output stays high while either flag is set. Both timer outputs come from another clock domain, so each passes through a two-flop synchronizer before it is used. The error inputs are taken to be synchronous to the block clock.

Top module: `sysctl_portb`

## Requirements
- R1: After reset a read of the register returns 0x0C when the counter 2 output is low. Counter 2 gate, speaker and NMI request are all low.
- R2: A write at address 0x0061 loads write-data bits 3:0 into register bits 3:0, which read back unchanged. A write at any other address changes nothing. A read at any other address returns 0x00.
- R3: Write-data bits 7:4 have no effect on register bits 7:4.
- R4: The counter 2 gate output equals register bit 0 from the clock after the write.
- R5: The speaker output is high only when register bit 1 is 1 and the synchronized counter 2 output is high.
- R6: Register bit 5 shows the counter 2 output after a two-flop synchronizer. A change appears after two clock edges and not after one.
- R7: Register bit 4 inverts once for each falling edge of the counter 1 output. A rising edge leaves it unchanged.
- R8: Register bit 7 becomes 1 one clock after a PCI error pulse that is sampled while bit 2 is 0. It then stays 1. A pulse sampled while bit 2 is 1 leaves it 0.
- R9: Writing 1 to register bit 2 clears bit 7. When a clear and a new error come in the same cycle, the clear wins.
- R10: Register bit 6 behaves in the same way for the I/O-check level, with bit 3 as its mask and its clear. While bit 3 is 1 the I/O-check input is ignored.
- R11: The NMI request output is high exactly while bit 7 or bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr_en | input | 1 | Write strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rd_en | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, zero when not selected |
| pci_err_pulse | input | 1 | PCI parity/system error pulse |
| iochk_err | input | 1 | I/O-check error level, active high |
| tmr_out1 | input | 1 | Timer counter 1 output, asynchronous |
| tmr_out2 | input | 1 | Timer counter 2 output, asynchronous |
| tmr_gate2 | output | 1 | Timer counter 2 gate |
| spkr_out | output | 1 | Speaker drive |
| nmi_req | output | 1 | NMI request |

## Verification
The assertions check, on every cycle, that each sticky flag rises only after an unmasked error and holds until it is cleared. They also check that a clear always takes effect, that the toggle bit changes only after a detected falling edge, and that the NMI request rises only from an unmasked source. The bench's scenarios are needed for the rest: address decode, that high write bits are ignored, the exact two-clock latency of the synchronized counter 2 bit, the count of toggle edges, and the speaker gating against live timer data.

// File: rtl/portb_pkg.sv
// Package: shared bit positions, control layout and reset value for the
// legacy Port B register. Assumes an 8-bit register with 4 control bits.
package portb_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned CTRL_W   = 4;
    localparam int unsigned BIT_TOG  = 4;
    localparam int unsigned BIT_OUT2 = 5;
    localparam int unsigned BIT_IOF  = 6;
    localparam int unsigned BIT_PCIF = 7;
    localparam int unsigned N_ERR    = 2;
    localparam int unsigned ERR_PCI  = 0;
    localparam int unsigned ERR_IOCK = 1;

    // Control bits in register order 3:0.
    typedef struct packed {
        logic io_mask;   // bit 3: 1 ignores I/O-check
        logic pci_mask;  // bit 2: 1 ignores PCI errors
        logic spk_en;    // bit 1: pass counter 2 to speaker
        logic gate2;     // bit 0: counter 2 gate
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{io_mask: 1'b1, pci_mask: 1'b1, spk_en: 1'b0, gate2: 1'b0};
endpackage

// File: rtl/portb_sync.sv
// Module: multi-stage flop synchronizer for a bundle of asynchronous bits.
// Assumes the bits are independent levels; no coherence between them is kept.
module portb_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/portb_fall_toggle.sv
// Module: detects falling edges of a synchronized level and flips a bit on each.
// Assumes the input is already synchronous to clk.
module portb_fall_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic tog_o
);
    logic prev_q;
    logic fall;

    assign fall = prev_q && !level_i;

    // Keep the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    // Invert the toggle bit on each detected falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    tog_o <= 1'b0;
        else if (fall) tog_o <= !tog_o;
    end

    assert_tog_only_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_o) |-> $past(fall));
endmodule

// File: rtl/portb_sticky_flag.sv
// Module: sticky error flag. Sets on an unmasked error, clears on request;
// clear has priority. Assumes set_i is synchronous to clk.
module portb_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic mask_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_o <= 1'b0;
        else if (clr_i)             flag_o <= 1'b0;
        else if (set_i && !mask_i)  flag_o <= 1'b1;
    end

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);
    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    assert_set_needs_unmasked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(set_i && !mask_i));
endmodule

// File: rtl/sysctl_portb.sv
// Module: legacy Port B status/control register with speaker gating, timer
// observation and sticky error flags driving an NMI request.
// Assumes error inputs are synchronous to clk; timer outputs are asynchronous.
module sysctl_portb #(
    parameter int unsigned       ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR   = 16'h0061,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr_en,
    input  logic [7:0]        io_wdata,
    input  logic              io_rd_en,
    output logic [7:0]        io_rdata,
    input  logic              pci_err_pulse,
    input  logic              iochk_err,
    input  logic              tmr_out1,
    input  logic              tmr_out2,
    output logic              tmr_gate2,
    output logic              spkr_out,
    output logic              nmi_req
);
    import portb_pkg::*;

    localparam int unsigned TMR_N = 2;

    ctrl_t              ctrl_q;
    logic               sel;
    logic               wr_hit;
    logic [TMR_N-1:0]   tmr_sync;
    logic               out1_s;
    logic               out2_s;
    logic               tog;
    logic [N_ERR-1:0]   err_in;
    logic [N_ERR-1:0]   err_mask;
    logic [N_ERR-1:0]   err_clr;
    logic [N_ERR-1:0]   err_flag;
    logic [3:0]         unused_wdata_hi;

    assign sel             = (io_addr == PORT_ADDR);
    assign wr_hit          = io_wr_en && sel;
    assign unused_wdata_hi = io_wdata[7:4];

    // Load the control bits on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= CTRL_RST;
        else if (wr_hit) ctrl_q <= ctrl_t'(io_wdata[CTRL_W-1:0]);
    end

    portb_sync #(.W(TMR_N), .STAGES(SYNC_STAGES)) u_tmr_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({tmr_out2, tmr_out1}),
        .sync_o  (tmr_sync)
    );
    assign out1_s = tmr_sync[0];
    assign out2_s = tmr_sync[1];

    portb_fall_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (out1_s),
        .tog_o   (tog)
    );

    // Error source mapping: index 0 PCI, index 1 I/O-check.
    assign err_in[ERR_PCI]    = pci_err_pulse;
    assign err_mask[ERR_PCI]  = ctrl_q.pci_mask;
    assign err_clr[ERR_PCI]   = wr_hit && io_wdata[2];
    assign err_in[ERR_IOCK]   = iochk_err;
    assign err_mask[ERR_IOCK] = ctrl_q.io_mask;
    assign err_clr[ERR_IOCK]  = wr_hit && io_wdata[3];

    for (genvar g = 0; g < int'(N_ERR); g++) begin : g_err
        portb_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (err_in[g]),
            .mask_i (err_mask[g]),
            .clr_i  (err_clr[g]),
            .flag_o (err_flag[g])
        );
    end

    assign tmr_gate2 = ctrl_q.gate2;
    assign spkr_out  = ctrl_q.spk_en && out2_s;
    assign nmi_req   = |err_flag;

    // Assemble read data; zero when not addressed.
    always_comb begin
        io_rdata = '0;
        if (io_rd_en && sel)
            io_rdata = {err_flag[ERR_PCI], err_flag[ERR_IOCK], out2_s, tog, ctrl_q};
    end

    assert_gate_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (tmr_gate2 == $past(io_wdata[0])));
    assert_spkr_muted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !io_wdata[1]) |=> !spkr_out);
    assert_nmi_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $past((pci_err_pulse && !ctrl_q.pci_mask) ||
                                 (iochk_err && !ctrl_q.io_mask)));
endmodule

// File: tb/sysctl_portb_tb.sv
// Directed bench for sysctl_portb: one task per scenario, each self-checking.
module sysctl_portb_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr_en = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd_en = 1'b0;
    logic [7:0]  io_rdata;
    logic        pci_err_pulse = 1'b0;
    logic        iochk_err = 1'b0;
    logic        tmr_out1 = 1'b0;
    logic        tmr_out2 = 1'b0;
    logic        tmr_gate2;
    logic        spkr_out;
    logic        nmi_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    sysctl_portb dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr_en(io_wr_en),
        .io_wdata(io_wdata), .io_rd_en(io_rd_en), .io_rdata(io_rdata),
        .pci_err_pulse(pci_err_pulse), .iochk_err(iochk_err),
        .tmr_out1(tmr_out1), .tmr_out2(tmr_out2), .tmr_gate2(tmr_gate2),
        .spkr_out(spkr_out), .nmi_req(nmi_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr_en = 1'b1;
        @(negedge clk);
        io_wr_en = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        io_addr = a; io_rd_en = 1'b1;
        #1 d = io_rdata;
        io_rd_en = 1'b0;
    endtask

    task automatic t_reset_R1();
        logic [7:0] d;
        io_read(16'h0061, d);
        chk("R1 reset value", d, 8'h0C);
        chk("R1 outputs low", {5'b0, tmr_gate2, spkr_out, nmi_req}, 8'h00);
    endtask

    task automatic t_ctrl_rw_R2();
        logic [7:0] d;
        io_write(16'h0061, 8'h09);
        io_read(16'h0061, d);
        chk("R2 control readback", d, 8'h09);
        io_write(16'h0060, 8'h06);
        io_read(16'h0061, d);
        chk("R2 other address no write", d, 8'h09);
        io_read(16'h0060, d);
        chk("R2 other address reads zero", d, 8'h00);
        io_write(16'h0061, 8'h0C);
    endtask

    task automatic t_high_ignored_R3();
        logic [7:0] d;
        io_write(16'h0061, 8'hFC);
        io_read(16'h0061, d);
        chk("R3 high write bits ignored", d, 8'h0C);
    endtask

    task automatic t_gate_R4();
        io_write(16'h0061, 8'h0D);
        chk("R4 gate high", {7'b0, tmr_gate2}, 8'h01);
        io_write(16'h0061, 8'h0C);
        chk("R4 gate low", {7'b0, tmr_gate2}, 8'h00);
    endtask

    task automatic t_out2_R6_spkr_R5();
        logic [7:0] d;
        tmr_out2 = 1'b1;
        wait_cyc(1);
        io_read(16'h0061, d);
        chk("R6 not visible after one edge", d & 8'h20, 8'h00);
        wait_cyc(1);
        io_read(16'h0061, d);
        chk("R6 visible after two edges", d & 8'h20, 8'h20);
        chk("R5 speaker muted with bit1=0", {7'b0, spkr_out}, 8'h00);
        io_write(16'h0061, 8'h0E);
        chk("R5 speaker passes counter 2", {7'b0, spkr_out}, 8'h01);
        tmr_out2 = 1'b0;
        wait_cyc(3);
        chk("R5 speaker follows counter 2 low", {7'b0, spkr_out}, 8'h00);
        io_read(16'h0061, d);
        chk("R6 low level visible", d & 8'h20, 8'h00);
        io_write(16'h0061, 8'h0C);
    endtask

    task automatic t_toggle_R7();
        logic [7:0] d;
        logic exp_t = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tmr_out1 = 1'b1;
            wait_cyc(5);
            io_read(16'h0061, d);
            chk("R7 rise leaves toggle", d & 8'h10, {3'b0, exp_t, 4'b0});
            tmr_out1 = 1'b0;
            exp_t = !exp_t;
            wait_cyc(5);
            io_read(16'h0061, d);
            chk("R7 fall inverts toggle", d & 8'h10, {3'b0, exp_t, 4'b0});
        end
    endtask

    task automatic t_pci_R8_R9();
        logic [7:0] d;
        pci_err_pulse = 1'b1; wait_cyc(1); pci_err_pulse = 1'b0;
        io_read(16'h0061, d);
        chk("R8 masked pulse ignored", d & 8'h80, 8'h00);
        chk("R11 no nmi when masked", {7'b0, nmi_req}, 8'h00);
        io_write(16'h0061, 8'h08);
        pci_err_pulse = 1'b1; wait_cyc(1); pci_err_pulse = 1'b0;
        io_read(16'h0061, d);
        chk("R8 unmasked pulse sets flag", d & 8'h80, 8'h80);
        chk("R11 nmi from pci flag", {7'b0, nmi_req}, 8'h01);
        wait_cyc(4);
        io_read(16'h0061, d);
        chk("R8 flag sticky", d & 8'h80, 8'h80);
        io_write(16'h0061, 8'h0C);
        io_read(16'h0061, d);
        chk("R9 write bit2=1 clears flag", d & 8'h80, 8'h00);
        chk("R11 nmi drops", {7'b0, nmi_req}, 8'h00);
        io_write(16'h0061, 8'h08);
        pci_err_pulse = 1'b1;
        io_write(16'h0061, 8'h0C);
        pci_err_pulse = 1'b0;
        io_read(16'h0061, d);
        chk("R9 clear wins over same-cycle error", d & 8'h80, 8'h00);
    endtask

    task automatic t_iochk_R10();
        logic [7:0] d;
        iochk_err = 1'b1;
        wait_cyc(2);
        io_read(16'h0061, d);
        chk("R10 masked level ignored", d & 8'h40, 8'h00);
        io_write(16'h0061, 8'h04);
        wait_cyc(1);
        iochk_err = 1'b0;
        io_read(16'h0061, d);
        chk("R10 unmasked level sets flag", d & 8'h40, 8'h40);
        chk("R11 nmi from iochk flag", {7'b0, nmi_req}, 8'h01);
        wait_cyc(3);
        io_read(16'h0061, d);
        chk("R10 flag sticky after level drops", d & 8'h40, 8'h40);
        iochk_err = 1'b1;
        io_write(16'h0061, 8'h0C);
        wait_cyc(2);
        io_read(16'h0061, d);
        chk("R10 bit3=1 clears and blocks", d & 8'h40, 8'h00);
        chk("R11 nmi low after clear", {7'b0, nmi_req}, 8'h00);
        iochk_err = 1'b0;
    endtask

    initial begin : watchdog
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset_R1();
        t_ctrl_rw_R2();
        t_high_ignored_R3();
        t_gate_R4();
        t_out2_R6_spkr_R5();
        t_toggle_R7();
        t_pci_R8_R9();
        t_iochk_R10();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule